// File: doc/BRIEF.md
# Open-Row DRAM Controller with Multiplexed Address Bus

This block takes single-supercell read and write requests from a processor-side port. It serves them from a small behavioural DRAM array that it contains. The array holds 16 supercells of 8 bits, arranged as 4 rows by 4 columns. Row and column numbers share one 2-bit address bus. Every access is split into a row phase and a column phase:

- **Row phase.** The row strobe is high and the row number is on the shared bus. The whole row is copied into a row buffer.
- **Column phase.** The column strobe is high and the column number is on the shared bus. One supercell moves between the row buffer and the data path.

The most recently opened row stays open. A following request to the same row skips the row phase.

A free-running timer raises a refresh request every `REFRESH_CYCLES` clock cycles. At 250 MHz, an interval of 10 to 100 ms corresponds to 2.5 to 25 million cycles. Refresh events walk the rows in ascending order, one row per event. Each refresh closes the open row.

Requests use a valid/ready handshake. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until that edge. `req_ready` is low during a row phase, a column phase or a refresh. It is also low while a refresh is pending, so a pending refresh wins over a waiting request. Read data comes back on a one-cycle `rsp_valid` pulse that cannot be stalled. Writes produce no response.

Top module: `rowbuf_dram_ctrl`

## Requirements
- R1: After reset:
  - `req_ready` is high and `ras_o`, `cas_o`, `rsp_valid` and `refresh_o` are low.
  - Every supercell reads as 0x00.
  - No row is open, so the first access takes a full row phase.
- R2: The 4-bit request address is split as follows:
  - bits [3:2] are the row and bits [1:0] are the column.
  - During a row phase `ras_o` is high and `mux_addr_o` carries the row.
  - During a column phase `cas_o` is high and `mux_addr_o` carries the column.
  - A row phase (not a refresh) is always followed by a column phase in the next cycle.
- R3: A read to a row that is not open takes one row-phase cycle and then one column-phase cycle. Its `rsp_valid` pulse, with the stored byte on `rsp_rdata`, appears 3 cycles after the accepting edge.
- R4: A request whose row equals the open row skips the row phase. A read then responds 2 cycles after the accepting edge. A write finishes in the same number of cycles.
- R5: A write updates both the row buffer and the array. A later read of that supercell returns the written byte, whether or not the row was closed in between.
- R6: `req_ready` is low while a row phase, column phase or refresh is in progress, so both strobes are low whenever `req_ready` is high. A request held with `req_valid` high waits until `req_ready` returns.
- R7: Refresh behaves as follows:
  - A refresh is requested every `REFRESH_CYCLES` cycles and takes priority over new requests.
  - `req_ready` drops one cycle before the refresh.
  - The refresh is a one-cycle pulse on `refresh_o`, with `ras_o` high and the refreshed row on `mux_addr_o`.
  - Rows are refreshed in the order 0, 1, 2, 3, 0, and so on.
  - With no traffic, refresh pulses are exactly `REFRESH_CYCLES` cycles apart.
- R8: A refresh closes the open row. The next access to any row starts with a row phase, and no column phase happens without a prior row phase.
- R9: A write produces no `rsp_valid` pulse.
- R10: `ras_o` and `cas_o` are never high together. `rsp_valid` is a single-cycle pulse that only follows a column-phase cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Flat supercell address (row in [3:2], column in [1:0]) |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid |
| ras_o | output | 1 | Row strobe (row phase or refresh) |
| cas_o | output | 1 | Column strobe |
| mux_addr_o | output | 2 | Shared row/column address bus |
| refresh_o | output | 1 | High during a refresh cycle |

## Verification
The bench builds the block with the default 4x4 geometry of 8-bit supercells and overrides `REFRESH_CYCLES` to 400. That short interval puts more than four refresh events into a run of a few thousand cycles. The row counter's wrap back to row 0 is therefore observed. The exact idle refresh spacing can be measured. A request can be timed to land on the cycle where a pending refresh blocks it. Observing latency (3 cycles versus 2) at the ports is how the bench tells open-row hits from misses. It also uses latency to show that a refresh closes the row.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2,
    ST_REF  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rbd_refresh_timer.sv
module rbd_refresh_timer #(
  parameter int INTERVAL = 2500000,
  parameter int ROW_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ack,
  output logic                pending,
  output logic [ROW_BITS-1:0] ref_row
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // a tick arriving while a refresh is being served is kept, not lost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (tick) begin
      pending <= 1'b1;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_row <= '0;
    end else if (ack) begin
      ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/rbd_cell_array.sv
module rbd_cell_array #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [ROW_BITS-1:0] load_row,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic [COL_BITS-1:0] wr_col,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [COL_BITS-1:0] rd_col,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [DATA_W-1:0] cells  [ROWS][COLS];
  logic [DATA_W-1:0] rowbuf [COLS];

  // storage array: write-through from the column phase
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          cells[r][c] <= '0;
        end
      end
    end else if (wr_en) begin
      cells[wr_row][wr_col] <= wr_data;
    end
  end

  // row buffer: whole-row copy on a row phase or refresh, single cell on write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) begin
        rowbuf[c] <= '0;
      end
    end else if (load_en) begin
      for (int c = 0; c < COLS; c++) begin
        rowbuf[c] <= cells[load_row][c];
      end
    end else if (wr_en) begin
      rowbuf[wr_col] <= wr_data;
    end
  end

  assign rd_data = rowbuf[rd_col];
endmodule

// File: rtl/rbd_sequencer.sv
module rbd_sequencer
  import rbd_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8,
  parameter int MUX_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata,
  input  logic                         ref_pending,
  input  logic [ROW_BITS-1:0]          ref_row,
  output logic                         ref_ack,
  output logic                         load_en,
  output logic [ROW_BITS-1:0]          load_row,
  output logic                         wr_en,
  output logic [ROW_BITS-1:0]          acc_row,
  output logic [COL_BITS-1:0]          acc_col,
  output logic [DATA_W-1:0]            acc_wdata,
  input  logic [DATA_W-1:0]            buf_rdata,
  output logic                         ras_o,
  output logic                         cas_o,
  output logic [MUX_W-1:0]             mux_addr_o,
  output logic                         refresh_o
);
  seq_state_t          state, state_nxt;
  logic                lat_write;
  logic                open_vld;
  logic [ROW_BITS-1:0] open_row;
  logic [ROW_BITS-1:0] req_row;
  logic [COL_BITS-1:0] req_col;
  logic                accept;

  assign req_row   = req_addr[ROW_BITS+COL_BITS-1:COL_BITS];
  assign req_col   = req_addr[COL_BITS-1:0];
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: begin
        if (ref_pending) begin
          state_nxt = ST_REF;
        end else if (req_valid) begin
          state_nxt = (open_vld && (open_row == req_row)) ? ST_COL : ST_ROW;
        end
      end
      ST_ROW:  state_nxt = ST_COL;
      ST_COL:  state_nxt = ST_IDLE;
      ST_REF:  state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      acc_row   <= '0;
      acc_col   <= '0;
      acc_wdata <= '0;
    end else if (accept) begin
      lat_write <= req_write;
      acc_row   <= req_row;
      acc_col   <= req_col;
      acc_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (state == ST_ROW) begin
      open_vld <= 1'b1;
      open_row <= acc_row;
    end else if (state == ST_REF) begin
      open_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (state == ST_COL) && !lat_write;
      if ((state == ST_COL) && !lat_write) begin
        rsp_rdata <= buf_rdata;
      end
    end
  end

  always_comb begin
    mux_addr_o = '0;
    case (state)
      ST_ROW:  mux_addr_o = MUX_W'(acc_row);
      ST_COL:  mux_addr_o = MUX_W'(acc_col);
      ST_REF:  mux_addr_o = MUX_W'(ref_row);
      default: mux_addr_o = '0;
    endcase
  end

  assign ras_o     = (state == ST_ROW) || (state == ST_REF);
  assign cas_o     = (state == ST_COL);
  assign refresh_o = (state == ST_REF);
  assign ref_ack   = (state == ST_REF);
  assign load_en   = ras_o;
  assign load_row  = (state == ST_REF) ? ref_row : acc_row;
  assign wr_en     = (state == ST_COL) && lat_write;
endmodule

// File: rtl/rowbuf_dram_ctrl.sv
module rowbuf_dram_ctrl #(
  parameter int REFRESH_CYCLES = 2500000,
  parameter int ROW_BITS       = 2,
  parameter int COL_BITS       = 2,
  parameter int DATA_W         = 8,
  localparam int ADDR_W        = ROW_BITS + COL_BITS,
  localparam int MUX_W         = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ras_o,
  output logic              cas_o,
  output logic [MUX_W-1:0]  mux_addr_o,
  output logic              refresh_o
);
  logic                ref_pending;
  logic [ROW_BITS-1:0] ref_row;
  logic                ref_ack;
  logic                load_en;
  logic [ROW_BITS-1:0] load_row;
  logic                wr_en;
  logic [ROW_BITS-1:0] acc_row;
  logic [COL_BITS-1:0] acc_col;
  logic [DATA_W-1:0]   acc_wdata;
  logic [DATA_W-1:0]   buf_rdata;

  rbd_refresh_timer #(
    .INTERVAL (REFRESH_CYCLES),
    .ROW_BITS (ROW_BITS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ref_ack),
    .pending (ref_pending),
    .ref_row (ref_row)
  );

  rbd_sequencer #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W),
    .MUX_W    (MUX_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_ack     (ref_ack),
    .load_en     (load_en),
    .load_row    (load_row),
    .wr_en       (wr_en),
    .acc_row     (acc_row),
    .acc_col     (acc_col),
    .acc_wdata   (acc_wdata),
    .buf_rdata   (buf_rdata),
    .ras_o       (ras_o),
    .cas_o       (cas_o),
    .mux_addr_o  (mux_addr_o),
    .refresh_o   (refresh_o)
  );

  rbd_cell_array #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_row (load_row),
    .wr_en    (wr_en),
    .wr_row   (acc_row),
    .wr_col   (acc_col),
    .wr_data  (acc_wdata),
    .rd_col   (acc_col),
    .rd_data  (buf_rdata)
  );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int REFRESH_CYCLES = 2500000,
  parameter int ROW_BITS       = 2,
  parameter int MUX_W          = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             ras_o,
  input logic             cas_o,
  input logic [MUX_W-1:0] mux_addr_o,
  input logic             refresh_o
);
  logic [ROW_BITS-1:0] exp_ref_row;
  logic                row_open;
  int unsigned         gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_ref_row <= '0;
      row_open    <= 1'b0;
      gap         <= 0;
    end else begin
      if (refresh_o) begin
        exp_ref_row <= exp_ref_row + 1'b1;
        row_open    <= 1'b0;
        gap         <= 0;
      end else begin
        gap <= gap + 1;
        if (ras_o) begin
          row_open <= 1'b1;
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_o && cas_o)); // R10
  AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_o && !refresh_o) |=> cas_o); // R2
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ras_o && !cas_o && !refresh_o)); // R6
  AST_RSP_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cas_o)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_REF_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> (mux_addr_o == MUX_W'(exp_ref_row))); // R7
  AST_REF_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> ras_o); // R7
  AST_REF_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= REFRESH_CYCLES + 4); // R7
  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    cas_o |-> row_open); // R8
endmodule

bind rowbuf_dram_ctrl rbd_checker #(
  .REFRESH_CYCLES (REFRESH_CYCLES),
  .ROW_BITS       (ROW_BITS),
  .MUX_W          (MUX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ras_o      (ras_o),
  .cas_o      (cas_o),
  .mux_addr_o (mux_addr_o),
  .refresh_o  (refresh_o)
);

// File: tb/rowbuf_dram_ctrl_tb.sv
module rowbuf_dram_ctrl_tb;
  localparam int REF_N = 400;
  localparam int NVEC  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       ras_o, cas_o, refresh_o;
  logic [1:0] mux_addr_o;

  int checks = 0;
  int failures = 0;
  int ref_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rowbuf_dram_ctrl #(.REFRESH_CYCLES(REF_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ras_o(ras_o), .cas_o(cas_o),
    .mux_addr_o(mux_addr_o), .refresh_o(refresh_o)
  );

  // {write, addr, wdata, expected read byte, expected latency}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 4'h5, 8'hA5, 8'h00, 2'd3},
    {1'b0, 4'h5, 8'h00, 8'hA5, 2'd2},
    {1'b1, 4'h6, 8'h3C, 8'h00, 2'd2},
    {1'b0, 4'h4, 8'h00, 8'h00, 2'd2},
    {1'b0, 4'h9, 8'h00, 8'h00, 2'd3},
    {1'b1, 4'h8, 8'hF0, 8'h00, 2'd2},
    {1'b0, 4'h6, 8'h00, 8'h3C, 2'd3},
    {1'b0, 4'h8, 8'h00, 8'hF0, 2'd3},
    {1'b1, 4'hF, 8'h77, 8'h00, 2'd3},
    {1'b0, 4'hC, 8'h00, 8'h00, 2'd2},
    {1'b0, 4'hF, 8'h00, 8'h77, 2'd2},
    {1'b0, 4'h0, 8'h00, 8'h00, 2'd3},
    {1'b1, 4'h0, 8'h11, 8'h00, 2'd2},
    {1'b0, 4'h0, 8'h00, 8'h11, 2'd2},
    {1'b0, 4'h5, 8'h00, 8'hA5, 2'd3},
    {1'b0, 4'hA, 8'h00, 8'h00, 2'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // refresh row order monitor (R7)
  always @(negedge clk) begin
    if (rst_n && refresh_o && !done) begin
      check(mux_addr_o == 2'(ref_seen) && ras_o, "R7 refresh row order",
            mux_addr_o, ref_seen % 4);
      ref_seen++;
    end
  end

  task automatic wait_refresh();
    @(negedge clk);
    while (!refresh_o) @(negedge clk);
  endtask

  // issues one request; lat = negedges after the accepting edge until
  // the read response (read) or the return of req_ready (write)
  task automatic do_req(input logic we, input logic [3:0] a, input logic [7:0] wd,
                        input int exp_lat, output int lat, output logic [7:0] rd,
                        output bit strobe_ok, output bit ready_ok, output bit norsp_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 99; rd = 8'h00; strobe_ok = 1'b1; ready_ok = 1'b1; norsp_ok = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      if (we && rsp_valid) norsp_ok = 1'b0;
      if (!we && rsp_valid) begin rd = rsp_rdata; lat = i; break; end
      if (we && req_ready) begin lat = i; break; end
      if (req_ready) ready_ok = 1'b0;
      if (exp_lat == 3 && i == 1 && !(ras_o && !cas_o && mux_addr_o == a[3:2])) strobe_ok = 1'b0;
      if (exp_lat == 3 && i == 2 && !(cas_o && !ras_o && mux_addr_o == a[1:0])) strobe_ok = 1'b0;
      if (exp_lat == 2 && i == 1 && !(cas_o && !ras_o && mux_addr_o == a[1:0])) strobe_ok = 1'b0;
      @(negedge clk);
    end
    if (we) begin
      for (int i = 0; i < 3; i++) begin
        if (rsp_valid) norsp_ok = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, t0, t1;
    logic [7:0] rd;
    bit s_ok, r_ok, n_ok;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    check({ras_o, cas_o, rsp_valid, refresh_o} === 4'b0, "R1 strobes low after reset",
          {ras_o, cas_o, rsp_valid, refresh_o}, 0);

    // R1: every cell is zero; first access of each row needs a row phase (R3, R4)
    for (int a = 0; a < 16; a++) begin
      do_req(1'b0, 4'(a), 8'h00, (a % 4 == 0) ? 3 : 2, lat, rd, s_ok, r_ok, n_ok);
      check(rd == 8'h00, "R1 cell zero after reset", rd, 0);
      check(lat == ((a % 4 == 0) ? 3 : 2), "R3/R4 latency in reset scan", lat,
            (a % 4 == 0) ? 3 : 2);
    end

    // align just after a refresh so the walk starts with no row open
    wait_refresh();
    for (int v = 0; v < NVEC; v++) begin
      logic       we;
      logic [3:0] a;
      logic [7:0] wd, ex;
      int         el;
      we = VEC[v][22]; a = VEC[v][21:18]; wd = VEC[v][17:10]; ex = VEC[v][9:2];
      el = int'(VEC[v][1:0]);
      do_req(we, a, wd, el, lat, rd, s_ok, r_ok, n_ok);
      check(lat == el, "R3/R4 latency", lat, el);
      check(s_ok, "R2 row/column strobes and shared address", s_ok, 1);
      check(r_ok, "R6 ready low during phases", r_ok, 1);
      if (we) check(n_ok, "R9 no response on write", n_ok, 1);
      else    check(rd == ex, "R5 read data", rd, ex);
    end

    // R7: idle refresh spacing
    wait_refresh();
    t0 = 0;
    @(negedge clk);
    t0 = 1;
    while (!refresh_o) begin @(negedge clk); t0++; end
    check(t0 == REF_N, "R7 idle refresh interval", t0, REF_N);

    // R7 priority: ready drops one cycle before the next refresh
    repeat (REF_N - 1) @(negedge clk);
    check(req_ready == 1'b0 && refresh_o == 1'b0, "R7 ready low while refresh pending",
          {req_ready, refresh_o}, 0);
    // request arrives during the refresh: held, then row phase again (R6, R8)
    do_req(1'b0, 4'h5, 8'h00, 3, lat, rd, s_ok, r_ok, n_ok);
    check(rd == 8'hA5, "R6 held request served after refresh", rd, 8'hA5);
    check(lat == 3, "R8 refresh closed row", lat, 3);
    do_req(1'b0, 4'h6, 8'h00, 2, lat, rd, s_ok, r_ok, n_ok);
    check(lat == 2 && rd == 8'h3C, "R4 open-row hit", lat, 2);

    wait_refresh();
    do_req(1'b0, 4'h6, 8'h00, 3, lat, rd, s_ok, r_ok, n_ok);
    check(lat == 3 && rd == 8'h3C, "R8 same row reopened after refresh", lat, 3);
    check(ref_seen >= 5, "R7 row counter wrapped", ref_seen, 5);

    t1 = 0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + t1);
    $finish;
  end
endmodule